// File: doc/BRIEF.md
# Five-Bank Interleaved Span Writer

This block sits between a rasterizer and five video-memory banks that together store a display 1280 pixels wide and 1024 lines tall. Neighbouring pixels go to the banks in rotation, so any five horizontally adjacent pixels land in five different banks and can be stored in one write cycle. The rasterizer hands over a span: a start column, a line number, a pixel count and up to five pixel values.

For each span the block works out which bank takes each pixel and the word inside that bank. The word is the line number times 256 plus the start column divided by five. The division uses a constant reciprocal multiply, so there is no divider. A span may start on any column. When it runs past the last bank and comes back round to bank 0, the banks after the wrap use the next column. A span that would cross the right edge of the line is cut short.

All five bank ports are registered and are written together, one cycle after the span is accepted. A valid/ready handshake holds the span off while any bank signals that it is busy.

Top module: `pix5_span_writer`

## Requirements
- R1: While reset is asserted, and after it is released until the first span is accepted, every bank write enable is low.
- R2: Pixel i of an accepted span (i counts from 0) has column x+i and is written to bank (x+i) mod 5. Its data is taken from in_data bits [8*i+7 : 8*i].
- R3: The bank word address of a pixel at column c on line y is y*256 + floor(c/5).
- R4: When a span starts at a column that is not a multiple of 5, the banks with a number lower than (x mod 5) that receive a pixel use in-bank column floor(x/5)+1. The other receiving banks use floor(x/5).
- R5: A bank that receives no pixel from a span keeps its write enable low in the write cycle.
- R6: Pixels at column 1280 or beyond are dropped. A span starting at x >= 1280 writes nothing, and a span that crosses the edge writes only columns up to 1279.
- R7: A count of 0 writes nothing. A count above 5 is treated as 5.
- R8: in_ready is low whenever any bank_busy bit is high. No span is taken and no bank is written in the following cycle.
- R9: The writes of an accepted span appear on the bank ports in the cycle right after the acceptance edge and last exactly one cycle. A cycle without acceptance is followed by a cycle with all write enables low.
- R10: A span of five pixels starting at a multiple of 5 writes all five banks in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A span is offered |
| in_ready | output | 1 | The span is taken at this edge when in_valid is high |
| in_x | input | 11 | Start column of the span |
| in_y | input | 10 | Line number |
| in_count | input | 3 | Number of pixels, 0 to 7 (values above 5 are capped) |
| in_data | input | 40 | Pixel values; pixel i in bits [8*i+7:8*i] |
| bank_busy | input | 5 | One bit per bank; high means the bank cannot take a write |
| bank_we | output | 5 | Write enable for each bank |
| bank_addr | output | 90 | Word address for each bank; bank b in bits [18*b+17:18*b] |
| bank_data | output | 40 | Write data for each bank; bank b in bits [8*b+7:8*b] |

## Verification
The only register stage is the output register. The write enables, addresses and data of a span are therefore due one cycle after the edge that accepts it, and every write enable must be low again one cycle later. Inputs change on the falling edge. The bench then samples the bank ports at the next falling edge, half a cycle after the write edge, and once more a full cycle later to confirm the enables have dropped. For in_ready no clock edge is involved, so the bench reads it in the same half cycle in which bank_busy changes. Bank-port results are then checked after the following edge, which must not have produced a write.

// File: rtl/pix5_pkg.sv
package pix5_pkg;

    // Default geometry of the interleaved frame store
    localparam int unsigned PIX_LINE_W    = 1280;
    localparam int unsigned PIX_LINES     = 1024;
    localparam int unsigned PIX_BANKS     = 5;
    localparam int unsigned PIX_DATA_W    = 8;

    // Position of a bank within a span whose first pixel sits in bank 'start'
    function automatic int unsigned ring_offset(input int unsigned bank,
                                                input int unsigned start,
                                                input int unsigned nb);
        if (bank >= start) return bank - start;
        return bank + nb - start;
    endfunction

endpackage

// File: rtl/pix5_colsplit.sv
// Splits a column into bank number and in-bank column without a divider:
// the quotient comes from a multiply by a rounded-up reciprocal.
module pix5_colsplit #(
    parameter int unsigned NB     = 5,
    parameter int unsigned X_W    = 11,
    parameter int unsigned BANK_W = 3
) (
    input  logic [X_W-1:0]    x,
    output logic [X_W-1:0]    q,
    output logic [BANK_W-1:0] rem
);
    localparam int unsigned SH    = X_W + $clog2(NB) + 1;
    localparam int unsigned RECIP = ((1 << SH) + NB - 1) / NB;
    localparam int unsigned PW    = X_W + SH;

    logic [PW-1:0]  prod;
    logic [X_W-1:0] back;

    always_comb begin
        prod = PW'(x) * PW'(RECIP);
        q    = X_W'(prod >> SH);
        back = X_W'(q * X_W'(NB));
        rem  = BANK_W'(x - back);
    end

endmodule

// File: rtl/pix5_spanclip.sv
// Number of pixels actually written: capped at one per bank and at the line end.
module pix5_spanclip #(
    parameter int unsigned NB     = 5,
    parameter int unsigned LINE_W = 1280,
    parameter int unsigned X_W    = 11,
    parameter int unsigned CNT_W  = 3
) (
    input  logic [X_W-1:0]   x,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] eff
);
    logic [X_W:0]   room;
    logic [CNT_W-1:0] cap;

    always_comb begin
        if ({1'b0, x} < (X_W+1)'(LINE_W))
            room = (X_W+1)'(LINE_W) - {1'b0, x};
        else
            room = '0;

        if (count > CNT_W'(NB)) cap = CNT_W'(NB);
        else                    cap = count;

        if (room < (X_W+1)'(cap)) eff = CNT_W'(room);
        else                      eff = cap;
    end

endmodule

// File: rtl/pix5_lane.sv
// One bank port: picks its pixel out of the span and forms its word address.
module pix5_lane
    import pix5_pkg::*;
#(
    parameter int unsigned NB     = 5,
    parameter int unsigned DW     = 8,
    parameter int unsigned COLS   = 256,
    parameter int unsigned X_W    = 11,
    parameter int unsigned Y_W    = 10,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned BANK_W = 3,
    parameter int unsigned AW     = 18,
    parameter int unsigned B      = 0
) (
    input  logic [BANK_W-1:0] rem,
    input  logic [X_W-1:0]    q,
    input  logic [Y_W-1:0]    y,
    input  logic [CNT_W-1:0]  eff,
    input  logic [NB*DW-1:0]  span_data,
    output logic              we,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     data
);
    int unsigned    off;
    logic           wrapped;
    logic [X_W-1:0] col;

    always_comb begin
        off     = ring_offset(B, 32'(rem), NB);
        wrapped = (32'(B) < 32'(rem));
        col     = q + X_W'(wrapped);
        we      = (off < 32'(eff));
        addr    = AW'(y) * AW'(COLS) + AW'(col);
        data    = span_data[off*DW +: DW];
    end

endmodule

// File: rtl/pix5_span_writer.sv
module pix5_span_writer
    import pix5_pkg::*;
#(
    parameter int unsigned LINE_W = PIX_LINE_W,
    parameter int unsigned LINES  = PIX_LINES,
    parameter int unsigned NB     = PIX_BANKS,
    parameter int unsigned DW     = PIX_DATA_W,
    parameter int unsigned COLS   = LINE_W / NB,
    parameter int unsigned X_W    = $clog2(LINE_W),
    parameter int unsigned Y_W    = $clog2(LINES),
    parameter int unsigned AW     = $clog2(LINES * COLS),
    parameter int unsigned CNT_W  = $clog2(NB + 1),
    parameter int unsigned BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [X_W-1:0]    in_x,
    input  logic [Y_W-1:0]    in_y,
    input  logic [CNT_W-1:0]  in_count,
    input  logic [NB*DW-1:0]  in_data,
    input  logic [NB-1:0]     bank_busy,
    output logic [NB-1:0]     bank_we,
    output logic [NB*AW-1:0]  bank_addr,
    output logic [NB*DW-1:0]  bank_data
);

    typedef struct packed {
        logic [NB-1:0]    we;
        logic [NB*AW-1:0] addr;
        logic [NB*DW-1:0] data;
    } wr_t;

    wr_t wr_d, wr_q;

    logic [X_W-1:0]    q_w;
    logic [BANK_W-1:0] rem_w;
    logic [CNT_W-1:0]  eff_w;
    logic [NB-1:0]     lane_we;
    logic [NB*AW-1:0]  lane_addr;
    logic [NB*DW-1:0]  lane_data;
    logic              take;

    pix5_colsplit #(.NB(NB), .X_W(X_W), .BANK_W(BANK_W)) u_split (
        .x   (in_x),
        .q   (q_w),
        .rem (rem_w)
    );

    pix5_spanclip #(.NB(NB), .LINE_W(LINE_W), .X_W(X_W), .CNT_W(CNT_W)) u_clip (
        .x     (in_x),
        .count (in_count),
        .eff   (eff_w)
    );

    for (genvar b = 0; b < NB; b++) begin : g_lane
        pix5_lane #(
            .NB(NB), .DW(DW), .COLS(COLS), .X_W(X_W), .Y_W(Y_W),
            .CNT_W(CNT_W), .BANK_W(BANK_W), .AW(AW), .B(b)
        ) u_lane (
            .rem       (rem_w),
            .q         (q_w),
            .y         (in_y),
            .eff       (eff_w),
            .span_data (in_data),
            .we        (lane_we[b]),
            .addr      (lane_addr[b*AW +: AW]),
            .data      (lane_data[b*DW +: DW])
        );
    end

    assign in_ready = ~(|bank_busy);
    assign take     = in_valid & in_ready;

    always_comb begin
        wr_d    = wr_q;
        wr_d.we = '0;
        if (take) begin
            wr_d.we   = lane_we;
            wr_d.addr = lane_addr;
            wr_d.data = lane_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign bank_we   = wr_q.we;
    assign bank_addr = wr_q.addr;
    assign bank_data = wr_q.data;

endmodule

// File: rtl/pix5_span_writer_chk.sv
module pix5_span_writer_chk #(
    parameter int unsigned LINE_W = 1280,
    parameter int unsigned NB     = 5,
    parameter int unsigned COLS   = 256,
    parameter int unsigned X_W    = 11,
    parameter int unsigned Y_W    = 10,
    parameter int unsigned AW     = 18,
    parameter int unsigned CNT_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [X_W-1:0]   in_x,
    input logic [Y_W-1:0]   in_y,
    input logic [CNT_W-1:0] in_count,
    input logic [NB-1:0]    bank_busy,
    input logic [NB-1:0]    bank_we,
    input logic [NB*AW-1:0] bank_addr
);
    int exp_n;

    always_comb begin
        int lim;
        lim = (int'(in_count) > int'(NB)) ? int'(NB) : int'(in_count);
        if (int'(in_x) >= int'(LINE_W))            exp_n = 0;
        else if (int'(LINE_W) - int'(in_x) < lim)  exp_n = int'(LINE_W) - int'(in_x);
        else                                       exp_n = lim;
    end

    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_busy) |=> (bank_we == '0));

    a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_ready)) |=> (bank_we == '0));

    a_r6_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ($countones(bank_we) == $past(exp_n)));

    for (genvar b = 0; b < NB; b++) begin : g_bank
        a_r3_same_line: assert property (@(posedge clk) disable iff (!rst_n)
            bank_we[b] |-> (int'(bank_addr[b*AW +: AW]) / int'(COLS) == int'($past(in_y))));

        a_r4_col_in_span: assert property (@(posedge clk) disable iff (!rst_n)
            bank_we[b] |->
              (((int'(bank_addr[b*AW +: AW]) % int'(COLS)) * int'(NB) + b >= int'($past(in_x))) &&
               ((int'(bank_addr[b*AW +: AW]) % int'(COLS)) * int'(NB) + b <  int'($past(in_x)) + int'(NB))));
    end

endmodule

bind pix5_span_writer pix5_span_writer_chk #(
    .LINE_W(LINE_W), .NB(NB), .COLS(COLS), .X_W(X_W),
    .Y_W(Y_W), .AW(AW), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_x      (in_x),
    .in_y      (in_y),
    .in_count  (in_count),
    .bank_busy (bank_busy),
    .bank_we   (bank_we),
    .bank_addr (bank_addr)
);

// File: tb/pix5_span_writer_tb.sv
module pix5_span_writer_tb;

    localparam int NB = 5;
    localparam int DW = 8;
    localparam int AW = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [10:0]     in_x = '0;
    logic [9:0]      in_y = '0;
    logic [2:0]      in_count = '0;
    logic [39:0]     in_data = '0;
    logic [4:0]      bank_busy = '0;
    logic [4:0]      bank_we;
    logic [89:0]     bank_addr;
    logic [39:0]     bank_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pix5_span_writer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_count(in_count), .in_data(in_data),
        .bank_busy(bank_busy), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_data(bank_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] make_data(input int seed);
        logic [39:0] d;
        for (int i = 0; i < NB; i++) d[i*DW +: DW] = 8'((seed + i * 37 + 1) & 8'hff);
        return d;
    endfunction

    // Compares the bank ports against the expected writes of one span
    task automatic expect_span(input int x, input int y, input int cnt,
                               input logic [39:0] d, input string tag);
        logic [4:0]  ewe = '0;
        logic [17:0] eaddr [NB];
        logic [7:0]  edat  [NB];
        int n;
        n = (cnt > 5) ? 5 : cnt;
        if (x >= 1280) n = 0;
        else if (1280 - x < n) n = 1280 - x;
        for (int b = 0; b < NB; b++) begin eaddr[b] = '0; edat[b] = '0; end
        for (int i = 0; i < n; i++) begin
            int c = x + i;
            int b = c % 5;
            ewe[b]   = 1'b1;
            eaddr[b] = 18'(y * 256 + c / 5);
            edat[b]  = d[i*DW +: DW];
        end
        chk(bank_we == ewe, {tag, " R5 write enables"}, longint'(bank_we), longint'(ewe));
        for (int b = 0; b < NB; b++) begin
            if (ewe[b]) begin
                chk(bank_addr[b*AW +: AW] == eaddr[b], {tag, " R3 address"},
                    longint'(bank_addr[b*AW +: AW]), longint'(eaddr[b]));
                chk(bank_data[b*DW +: DW] == edat[b], {tag, " R2 data"},
                    longint'(bank_data[b*DW +: DW]), longint'(edat[b]));
            end
        end
    endtask

    // Offers one span on a free bus and checks its writes, then the idle cycle after
    task automatic run_span(input int x, input int y, input int cnt, input int seed,
                            input string tag);
        logic [39:0] d = make_data(seed);
        @(negedge clk);
        in_valid = 1'b1; in_x = 11'(x); in_y = 10'(y); in_count = 3'(cnt); in_data = d;
        chk(in_ready == 1'b1, {tag, " R8 ready when free"}, longint'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        expect_span(x, y, cnt, d, tag);
        @(negedge clk);
        chk(bank_we == '0, {tag, " R9 single write cycle"}, longint'(bank_we), 0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(bank_we == '0, "R1 enables low in reset", longint'(bank_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bank_we == '0, "R1 enables low after reset", longint'(bank_we), 0);
    endtask

    task automatic test_aligned();
        run_span(0, 0, 5, 3, "R10 aligned full span");
        run_span(640, 77, 5, 9, "R10 aligned full span mid line");
    endtask

    task automatic test_wrap();
        run_span(7, 2, 5, 20, "R4 wrap from bank 2");
        run_span(14, 300, 4, 41, "R4 wrap from bank 4");
        run_span(1, 5, 5, 60, "R4 wrap from bank 1");
    endtask

    task automatic test_partial();
        run_span(3, 12, 2, 70, "R5 two pixels");
        run_span(22, 900, 1, 80, "R2 single pixel");
    endtask

    task automatic test_clip();
        run_span(1278, 10, 5, 90, "R6 clip at edge");
        run_span(1279, 1023, 5, 91, "R6 last column");
        run_span(1275, 1023, 5, 92, "R6 last five");
        run_span(1280, 4, 3, 93, "R6 start past edge");
        run_span(2000, 4, 5, 94, "R6 start far past edge");
    endtask

    task automatic test_count();
        run_span(10, 1, 0, 95, "R7 count zero");
        run_span(10, 1, 7, 96, "R7 count seven capped");
        run_span(11, 1, 6, 97, "R7 count six capped");
    endtask

    task automatic test_busy();
        logic [39:0] d = make_data(123);
        @(negedge clk);
        bank_busy = 5'b00100;
        in_valid = 1'b1; in_x = 11'd33; in_y = 10'd44; in_count = 3'd5; in_data = d;
        #1;
        chk(in_ready == 1'b0, "R8 ready low when busy", longint'(in_ready), 0);
        @(negedge clk);
        chk(bank_we == '0, "R8 no write while busy", longint'(bank_we), 0);
        @(negedge clk);
        chk(bank_we == '0, "R8 still no write while busy", longint'(bank_we), 0);
        bank_busy = 5'b00000;
        #1;
        chk(in_ready == 1'b1, "R8 ready back when free", longint'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        expect_span(33, 44, 5, d, "R8 span after stall");
        @(negedge clk);
        chk(bank_we == '0, "R9 enables drop after stalled span", longint'(bank_we), 0);
    endtask

    task automatic test_sweep();
        int unsigned s = 32'h1234_5678;
        for (int k = 0; k < 60; k++) begin
            int x, y, c;
            s = s * 1103515245 + 12345;
            x = int'((s >> 8) % 1300);
            s = s * 1103515245 + 12345;
            y = int'((s >> 8) % 1024);
            s = s * 1103515245 + 12345;
            c = int'((s >> 8) % 8);
            run_span(x, y, c, k * 13, "R2 sweep");
        end
    endtask

    initial begin
        test_reset();
        test_aligned();
        test_wrap();
        test_partial();
        test_clip();
        test_count();
        test_busy();
        test_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule